// File: doc/BRIEF.md
# Function-Code Bank-Switching Address Translator

This block sits between an 8-bit CPU's 16-bit logical address bus and a 1 MB physical memory system. With every access the CPU gives a 2-bit address-function code that says what kind of reference it is. The block picks a separate translation path for each kind. Code fetches and general data go through their own banks of sixteen 4 KB page registers. Return-stack references go to a fixed 64 KB window and are checked against a per-mode window of legal addresses. Direct-page references are mapped in 128-byte halves through four small latches, chosen by the half and by the system/user state.

The CPU loads the translation registers through a separate configuration port whose addresses start at zero. Translation is combinational from the registers. A register write changes translation from the next cycle onward. The block also blocks the write strobe on any illegal access: a write to a protected page, or a stack reference outside its window. When that happens it raises a sticky violation interrupt, which software clears through the configuration port. At reset every page register holds an identity mapping, so the machine starts out as a flat 64 KB space.

Top module: `fc_bank_mmu`

## Requirements
- R1: The function code `acc_fc` is encoded as 00 = direct page, 01 = return stack, 10 = general data and 11 = code fetch. For 10 and 11, logical bits 15:12 select one of sixteen page registers. Code and data each have their own set. `phys_addr[19:12]` is bits 7:0 of the selected register, and `phys_addr[11:0]` equals `acc_addr[11:0]`.
- R2: After reset, every code and data page register i holds frame i with write protection clear. Code and data accesses then give `phys_addr == acc_addr`, and `viol_irq` is low.
- R3: For a return-stack reference (fc 01), `phys_addr` is `0x10000 + acc_addr`.
- R4: `stk_err` is high on a valid stack reference whose address is below the current mode's lower bound or above its upper bound. Both bounds are inclusive. After reset the bounds are 0x0000 and 0xFFFF in both modes.
- R5: For a direct-page reference (fc 00), the latch index is `{sys_mode, acc_addr[7]}`. The result is `phys_addr = {4'b0, acc_addr[7], latch[7:0], acc_addr[6:0]}`, so the lower half lands in 0x0000–0x7FFF and the upper half in 0x8000–0xFFFF. All latches reset to zero.
- R6: The configuration addresses are laid out as follows:
  - 0–15: code page registers, where `cfg_wdata[7:0]` is the frame and bit 8 is write-protect.
  - 16–31: data page registers, with the same fields.
  - 32–35: direct-page latches, where the index is `cfg_addr[1:0]`.
  - 36/37: user-mode lower/upper stack bound.
  - 38/39: system-mode lower/upper stack bound.
  - 40: clears the interrupt.
- R7: A configuration write takes effect on the clock edge that ends its cycle. An access in the same cycle still sees the old value.
- R8: `wp_hit` is high exactly on a valid write with fc 10 or 11 whose page register has write-protect set. Reads of such a page translate normally.
- R9: `viol_irq` rises on the edge after a cycle with `wp_hit` or `stk_err`. It stays high until a write to address 40 in a cycle with no new violation. If a violation and a clear happen in the same cycle, the interrupt stays set.
- R10: `mem_we` equals `acc_valid & acc_write` unless `wp_hit` or `stk_err` is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | CPU access in this cycle |
| acc_write | input | 1 | Access is a write |
| acc_fc | input | 2 | Address-function code |
| acc_addr | input | 16 | Logical address |
| sys_mode | input | 1 | 1 = system state, 0 = user state |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_addr | input | 6 | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| phys_addr | output | 20 | Translated physical address |
| mem_we | output | 1 | Write strobe passed to memory |
| wp_hit | output | 1 | Write to a protected page |
| stk_err | output | 1 | Stack reference outside bounds |
| viol_irq | output | 1 | Sticky protection-violation interrupt |

## Verification
The bench probes the stack window at each inclusive edge and one address beyond it, in both modes. An off-by-one comparison or a swapped mode selection would flag a legal push, or pass an overrun silently. It writes a page register in the same cycle as an access through that page. A design that bypassed the new value, or delayed it a cycle more, would translate to the wrong frame. It also issues an interrupt clear in the same cycle as a new violation, which a clear-priority design would lose. Finally, it reads a protected page to show that protection affects only writes.

// File: rtl/fc_bank_mmu.sv
module fc_bank_mmu (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic [1:0]  acc_fc,
  input  logic [15:0] acc_addr,
  input  logic        sys_mode,
  input  logic        cfg_we,
  input  logic [5:0]  cfg_addr,
  input  logic [15:0] cfg_wdata,
  output logic [19:0] phys_addr,
  output logic        mem_we,
  output logic        wp_hit,
  output logic        stk_err,
  output logic        viol_irq
);

  localparam logic [5:0] IRQ_CLR = 6'd40;

  logic [8:0]  code_pg [16];
  logic [8:0]  data_pg [16];
  logic [7:0]  dp_lat  [4];
  logic [15:0] stk_lo  [2];
  logic [15:0] stk_hi  [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin
        code_pg[i] <= 9'(i);
        data_pg[i] <= 9'(i);
      end
      for (int i = 0; i < 4; i++) dp_lat[i] <= 8'h00;
      for (int i = 0; i < 2; i++) begin
        stk_lo[i] <= 16'h0000;
        stk_hi[i] <= 16'hFFFF;
      end
    end else if (cfg_we) begin
      case (cfg_addr[5:4])
        2'b00: code_pg[cfg_addr[3:0]] <= cfg_wdata[8:0];
        2'b01: data_pg[cfg_addr[3:0]] <= cfg_wdata[8:0];
        2'b10: begin
          if (cfg_addr[3:2] == 2'b00)
            dp_lat[cfg_addr[1:0]] <= cfg_wdata[7:0];
          else if (cfg_addr[3:2] == 2'b01) begin
            if (cfg_addr[0]) stk_hi[cfg_addr[1]] <= cfg_wdata;
            else             stk_lo[cfg_addr[1]] <= cfg_wdata;
          end
        end
        default: ;
      endcase
    end
  end

  logic [8:0] pg;
  logic [7:0] lat;
  assign pg  = acc_fc[0] ? code_pg[acc_addr[15:12]] : data_pg[acc_addr[15:12]];
  assign lat = dp_lat[{sys_mode, acc_addr[7]}];

  always_comb begin
    case (acc_fc)
      2'b00:   phys_addr = {4'h0, acc_addr[7], lat, acc_addr[6:0]};
      2'b01:   phys_addr = {4'h1, acc_addr};
      default: phys_addr = {pg[7:0], acc_addr[11:0]};
    endcase
  end

  assign wp_hit  = acc_valid & acc_write & acc_fc[1] & pg[8];
  assign stk_err = acc_valid & (acc_fc == 2'b01) &
                   ((acc_addr < stk_lo[sys_mode]) | (acc_addr > stk_hi[sys_mode]));
  assign mem_we  = acc_valid & acc_write & ~wp_hit & ~stk_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               viol_irq <= 1'b0;
    else if (wp_hit | stk_err)                viol_irq <= 1'b1;
    else if (cfg_we && cfg_addr == IRQ_CLR)   viol_irq <= 1'b0;
  end

endmodule

module fc_bank_mmu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic        acc_write,
  input logic [1:0]  acc_fc,
  input logic [15:0] acc_addr,
  input logic [19:0] phys_addr,
  input logic        mem_we,
  input logic        wp_hit,
  input logic        stk_err,
  input logic        viol_irq
);

  assert_page_offset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fc[1] |-> phys_addr[11:0] == acc_addr[11:0]);

  assert_stack_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fc == 2'b01) |-> phys_addr == {4'h1, acc_addr});

  assert_dp_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fc == 2'b00) |-> (phys_addr[19:16] == 4'h0 && phys_addr[15] == acc_addr[7]
                           && phys_addr[6:0] == acc_addr[6:0]));

  assert_wp_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wp_hit |-> (acc_valid && acc_write && acc_fc[1]));

  assert_irq_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_hit || stk_err) |=> viol_irq);

  assert_blocked_we_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_hit || stk_err || !acc_write) |-> !mem_we);

endmodule

bind fc_bank_mmu fc_bank_mmu_chk u_chk (.*);

// File: tb/tb_fc_bank_mmu.sv
`timescale 1ns/1ps
module tb_fc_bank_mmu;
  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_write = 0, sys_mode = 0, cfg_we = 0;
  logic [1:0] acc_fc = 0;
  logic [15:0] acc_addr = 0, cfg_wdata = 0;
  logic [5:0] cfg_addr = 0;
  logic [19:0] phys_addr;
  logic mem_we, wp_hit, stk_err, viol_irq;

  always #4 clk = ~clk;

  fc_bank_mmu dut (.*);

  int m_code[16], m_data[16], m_dp[4], m_lo[2], m_hi[2];
  bit m_irq;
  int n_chk = 0, n_fail = 0;
  string ph = "";

  task automatic check(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) begin m_code[i] = i; m_data[i] = i; end
    for (int i = 0; i < 4; i++) m_dp[i] = 0;
    for (int i = 0; i < 2; i++) begin m_lo[i] = 0; m_hi[i] = 'hFFFF; end
    m_irq = 0;
  endtask

  task automatic cyc(bit v, bit w, int fc, int a, bit s, bit cw, int ca, int cd);
    int e_pa, ent, idx;
    bit e_wp, e_se, e_we;
    acc_valid = v; acc_write = w; acc_fc = 2'(fc); acc_addr = 16'(a);
    sys_mode = s; cfg_we = cw; cfg_addr = 6'(ca); cfg_wdata = 16'(cd);
    #1;
    ent = (fc == 3) ? m_code[a >> 12] : m_data[a >> 12];
    case (fc)
      0: begin idx = s * 2 + ((a >> 7) & 1);
               e_pa = (((a >> 7) & 1) << 15) | (m_dp[idx] << 7) | (a & 127); end
      1: e_pa = 'h10000 + a;
      default: e_pa = ((ent & 255) << 12) | (a & 'hFFF);
    endcase
    e_wp = v && w && fc >= 2 && ((ent >> 8) & 1);
    e_se = v && fc == 1 && (a < m_lo[s] || a > m_hi[s]);
    e_we = v && w && !e_wp && !e_se;
    check(ph != "" ? ph : (fc == 1 ? "R3" : (fc == 0 ? "R5" : "R1")), phys_addr, e_pa);
    check("R8", wp_hit, e_wp);
    check("R4", stk_err, e_se);
    check("R10", mem_we, e_we);
    check("R9", viol_irq, m_irq);
    @(posedge clk);
    if (e_wp || e_se) m_irq = 1;
    else if (cw && ca == 40) m_irq = 0;
    if (cw) begin
      if (ca < 16) m_code[ca] = cd & 'h1FF;
      else if (ca < 32) m_data[ca - 16] = cd & 'h1FF;
      else if (ca < 36) m_dp[ca - 32] = cd & 255;
      else if (ca < 40) begin
        if (ca & 1) m_hi[(ca >> 1) & 1] = cd & 'hFFFF;
        else        m_lo[(ca >> 1) & 1] = cd & 'hFFFF;
      end
    end
    @(negedge clk);
  endtask

  task automatic cfg(int ca, int cd);
    cyc(0, 0, 2, 0, 0, 1, ca, cd);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R2: identity boot mapping, no interrupt
    ph = "R2";
    cyc(1, 0, 3, 'h1234, 0, 0, 0, 0);
    cyc(1, 1, 2, 'hF00F, 1, 0, 0, 0);
    for (int i = 0; i < 16; i++) cyc(1, 0, i % 2 ? 3 : 2, (i << 12) | 'h0A5, 0, 0, 0, 0);
    ph = "";
    // R7/R6: write code page 1 while accessing it; old frame then new
    ph = "R7";
    cyc(1, 0, 3, 'h1234, 0, 1, 1, 'h0AB);
    cyc(1, 0, 3, 'h1234, 0, 0, 0, 0);
    ph = "R6";
    cfg(17, 'h155);                      // data page 1, frame 55, protected
    cfg(15, 'h0FF);                      // code page 15
    cyc(1, 0, 2, 'h1ABC, 0, 0, 0, 0);    // data sees 55
    cyc(1, 0, 3, 'h1ABC, 0, 0, 0, 0);    // code sees AB (separate sets, R1)
    cyc(1, 0, 3, 'hFFFF, 0, 0, 0, 0);
    ph = "";
    // R8: protected page, read then write
    cyc(1, 0, 2, 'h1000, 0, 0, 0, 0);
    cyc(1, 1, 2, 'h1000, 0, 0, 0, 0);
    cyc(1, 1, 3, 'h1000, 0, 0, 0, 0);    // code page 1 unprotected
    // R9: clear works, and loses to a simultaneous violation
    cyc(0, 0, 2, 0, 0, 1, 40, 0);
    cyc(1, 1, 2, 'h1FFF, 0, 1, 40, 0);
    cyc(0, 0, 2, 0, 0, 0, 0, 0);
    cyc(0, 0, 2, 0, 0, 1, 40, 0);
    // R4: bounds, user 0100..01FF, system 8000..80FF
    cfg(36, 'h0100); cfg(37, 'h01FF); cfg(38, 'h8000); cfg(39, 'h80FF);
    cyc(1, 0, 1, 'h0100, 0, 0, 0, 0);
    cyc(1, 0, 1, 'h00FF, 0, 0, 0, 0);
    cyc(1, 1, 1, 'h01FF, 0, 0, 0, 0);
    cyc(1, 1, 1, 'h0200, 0, 0, 0, 0);    // R10 strobe blocked
    cyc(1, 1, 1, 'h8000, 1, 0, 0, 0);
    cyc(1, 0, 1, 'h7FFF, 1, 0, 0, 0);
    cyc(1, 0, 1, 'h80FF, 1, 0, 0, 0);
    cyc(1, 0, 1, 'h8100, 1, 1, 40, 0);
    cyc(1, 0, 1, 'h0150, 1, 0, 0, 0);    // user-legal, system-illegal
    cyc(0, 1, 1, 'h0000, 0, 1, 40, 0);   // not valid: no error
    // R5: four direct-page latches
    cyc(1, 0, 0, 'h0013, 0, 0, 0, 0);
    cfg(32, 'h11); cfg(33, 'h22); cfg(34, 'h33); cfg(35, 'hFF);
    for (int k = 0; k < 4; k++)
      cyc(1, k % 2, 0, (k % 2) ? 'h00FF : 'h0001, k / 2, 0, 0, 0);
    cyc(1, 1, 0, 'h007F, 1, 0, 0, 0);
    // R1 sweep over remapped data pages
    for (int i = 0; i < 16; i++) cfg(16 + i, 'hF0 - i);
    for (int i = 0; i < 16; i++) cyc(1, 1, 2, (i << 12) | 'h5A5, 0, 0, 0, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule